// File: doc/BRIEF.md
# Regulator Startup and Fault Sequencer

This block is the control state machine of a multiphase buck regulator. After the supply is good it rests in a disabled state. When enable arrives it runs a timed calibration interval and raises the gate-driver enable partway through that interval. It then waits for the external driver-ready sense, runs soft start, and settles in regulation. Each phase output is a three-level drive command: low-side on, mid/diode (both switches off), or active switching. During soft start a phase leaves the mid level on its own first PWM pulse.

Faults come from analog comparator flags that lie outside the block. During soft start, over-voltage is judged against a fixed absolute limit. In regulation it is judged against the DAC value plus a margin. Current has two limits: a 100% limit that must persist for a programmable filter time and a 150% limit that trips at once. Over-voltage and over-current shutdowns latch. Only a low enable or a loss of supply-good clears them. An under-voltage flag only drops the ready output while it is present. All time intervals are parameters counted in clock cycles.

Top module: `vr_seq_ctrl`

## Requirements
- R1: Out of reset, and on the cycle after enable is seen low, every phase mode is mid (code 2'b01), driver enable is 0, ready is 0 and both fault flags are 0.
- R2: The clock edge that accepts enable starts calibration. Phase modes stay mid for CAL_CYC cycles, and driver enable rises exactly DRV_CYC cycles after that edge.
- R3: After calibration, while the driver-ready sense is low, phase modes stay mid and ready stays 0. The first edge that sees the sense high starts soft start.
- R4: In soft start, phase i shows mid until the cycle its PWM pulse input is first high. From that cycle on it shows active (code 2'b10) until soft start ends. Ready is 0 in soft start.
- R5: The edge that sees soft-start-done moves to regulation. There every phase is active regardless of its pulses, and ready is 1.
- R6: In soft start, the absolute over-voltage flag causes an over-voltage shutdown on the next edge, and the DAC-relative over-voltage flag is ignored. In regulation the absolute flag is ignored.
- R7: In regulation, the DAC-relative over-voltage flag causes a shutdown on the next edge. The over-voltage fault flag is set, every phase mode is low (code 2'b00) and ready is 0. This state holds after the flag clears.
- R8: In soft start or regulation, the 150% current flag causes an over-current shutdown on the next edge. The over-current fault flag is set and every phase mode is low.
- R9: The 100% current flag causes an over-current shutdown only when it is high on OC_CYC consecutive edges. A shorter run, followed by a low cycle, restarts the count.
- R10: In regulation the under-voltage flag drops ready while it is high, with no latching. Ready returns when the flag clears.
- R11: A latched fault clears only when enable is low (to the disabled state) or supply-good is low. A low supply-good returns the block to reset from any state, including a fault.
- R12: When over-voltage and over-current conditions are present on the same edge, the over-voltage shutdown wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok_i | input | 1 | Supply above undervoltage lockout |
| en_i | input | 1 | Regulator enable |
| dron_i | input | 1 | Driver-ready sense (low while an external driver holds it) |
| ss_done_i | input | 1 | Soft-start ramp reached its target |
| pwm_i | input | NPH | Per-phase PWM pulse from the modulator |
| ov_abs_i | input | 1 | Output above absolute startup limit |
| ov_dac_i | input | 1 | Output above DAC plus margin |
| uv_i | input | 1 | Output below DAC minus droop minus margin |
| oc100_i | input | 1 | Current above 100% limit |
| oc150_i | input | 1 | Current above 150% limit |
| pwm_mode_o | output | 2*NPH | Per-phase mode, phase i in bits [2i+1:2i]: 00 low, 01 mid, 10 active |
| drv_en_o | output | 1 | Gate-driver enable drive |
| ready_o | output | 1 | Output regulating |
| ov_flag_o | output | 1 | Latched over-voltage shutdown |
| oc_flag_o | output | 1 | Latched over-current shutdown |

## Verification
An over-voltage trip and an over-current trip can fall on the same clock edge in regulation, and only one shutdown state can be taken. The bench raises the DAC-relative over-voltage flag and the 150% current flag together. It then expects the over-voltage flag set and the over-current flag clear on the next cycle. The 100% filter also meets the under-voltage and pulse inputs in the same cycles during a randomized stretch of regulation. There the bench expects ready to follow only the under-voltage flag and no shutdown from sub-threshold current bursts.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;

  typedef enum logic [1:0] {
    PH_LOW = 2'b00,
    PH_MID = 2'b01,
    PH_ACT = 2'b10
  } ph_mode_t;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_OFF,
    ST_CAL,
    ST_WAIT_DRV,
    ST_SOFT,
    ST_RUN,
    ST_FLT_OV,
    ST_FLT_OC
  } seq_state_t;

endpackage

// File: rtl/vr_seq_delay.sv
// Saturating run-length counter: done while run has been high for LIMIT edges.
module vr_seq_delay #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // R9: a stopped run always restarts the count from zero
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/vr_seq_phase.sv
// Per-phase three-level mode with first-pulse release during soft start.
module vr_seq_phase
  import vr_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_i,
  input  logic     run_i,
  input  logic     fault_i,
  input  logic     pulse_i,
  output ph_mode_t mode_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 armed_q <= 1'b0;
    else if (!(soft_i || run_i)) armed_q <= 1'b0;
    else if (pulse_i)           armed_q <= 1'b1;
  end

  always_comb begin
    if (fault_i)                             mode_o = PH_LOW;
    else if (run_i)                          mode_o = PH_ACT;
    else if (soft_i && (armed_q || pulse_i)) mode_o = PH_ACT;
    else                                     mode_o = PH_MID;
  end

  // R4: once released in soft start, a phase stays active
  a_r4_stay_active: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_i && $past(soft_i) && $past(mode_o == PH_ACT)) |-> (mode_o == PH_ACT));

endmodule

// File: rtl/vr_seq_ctrl.sv
module vr_seq_ctrl
  import vr_seq_pkg::*;
#(
  parameter int NPH     = 3,
  parameter int CAL_CYC = 875000,
  parameter int DRV_CYC = 625000,
  parameter int OC_CYC  = 12500
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           supply_ok_i,
  input  logic           en_i,
  input  logic           dron_i,
  input  logic           ss_done_i,
  input  logic [NPH-1:0] pwm_i,
  input  logic           ov_abs_i,
  input  logic           ov_dac_i,
  input  logic           uv_i,
  input  logic           oc100_i,
  input  logic           oc150_i,
  output logic [2*NPH-1:0] pwm_mode_o,
  output logic           drv_en_o,
  output logic           ready_o,
  output logic           ov_flag_o,
  output logic           oc_flag_o
);
  localparam logic [2*NPH-1:0] ALL_MID = {NPH{2'b01}};

  seq_state_t st_q, st_d;
  logic active, in_soft, in_run, in_fault;
  logic cal_done, drv_done, oc_done;
  logic drv_q;

  assign active   = (st_q != ST_RESET) && (st_q != ST_OFF);
  assign in_soft  = (st_q == ST_SOFT);
  assign in_run   = (st_q == ST_RUN);
  assign in_fault = (st_q == ST_FLT_OV) || (st_q == ST_FLT_OC);

  vr_seq_delay #(.LIMIT(CAL_CYC)) u_cal (
    .clk(clk), .rst_n(rst_n), .run_i(st_q == ST_CAL), .done_o(cal_done));

  vr_seq_delay #(.LIMIT(DRV_CYC)) u_drv (
    .clk(clk), .rst_n(rst_n), .run_i(active), .done_o(drv_done));

  vr_seq_delay #(.LIMIT(OC_CYC)) u_oc (
    .clk(clk), .rst_n(rst_n), .run_i((in_soft || in_run) && oc100_i), .done_o(oc_done));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RESET:    if (supply_ok_i) st_d = ST_OFF;
      ST_OFF:      if (en_i) st_d = ST_CAL;
      ST_CAL:      if (cal_done) st_d = ST_WAIT_DRV;
      ST_WAIT_DRV: if (dron_i) st_d = ST_SOFT;
      ST_SOFT: begin
        if (ov_abs_i)                st_d = ST_FLT_OV;
        else if (oc150_i || oc_done) st_d = ST_FLT_OC;
        else if (ss_done_i)          st_d = ST_RUN;
      end
      ST_RUN: begin
        if (ov_dac_i)                st_d = ST_FLT_OV;
        else if (oc150_i || oc_done) st_d = ST_FLT_OC;
      end
      default: st_d = st_q;
    endcase
    if (!en_i && (st_q != ST_RESET)) st_d = ST_OFF;
    if (!supply_ok_i)                st_d = ST_RESET;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_RESET;
      drv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      drv_q <= drv_done && en_i && supply_ok_i;
    end
  end

  ph_mode_t ph_mode [NPH];

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    vr_seq_phase u_phase (
      .clk(clk), .rst_n(rst_n), .soft_i(in_soft), .run_i(in_run),
      .fault_i(in_fault), .pulse_i(pwm_i[g]), .mode_o(ph_mode[g]));
    assign pwm_mode_o[2*g +: 2] = ph_mode[g];
  end

  assign drv_en_o  = drv_q;
  assign ready_o   = in_run && !uv_i;
  assign ov_flag_o = (st_q == ST_FLT_OV);
  assign oc_flag_o = (st_q == ST_FLT_OC);

  // R1: a low enable leaves every phase mid and the driver released
  a_r1_off_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pwm_mode_o == ALL_MID) && !drv_en_o && !ready_o);

  // R7: over-voltage shutdown holds while enable and supply stay high
  a_r7_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag_o && en_i && supply_ok_i) |=> ov_flag_o);

  // R7: any shutdown forces low-side on and no ready
  a_r7_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag_o || oc_flag_o) |-> (pwm_mode_o == '0) && !ready_o);

  // R9: an over-current shutdown needs a current flag the cycle before
  a_r9_oc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_flag_o) |-> $past(oc100_i || oc150_i));

  // R10: ready never stands with under-voltage present
  a_r10_uv_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !uv_i && drv_en_o);

  // R11: supply loss clears every latch
  a_r11_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> !ov_flag_o && !oc_flag_o && (pwm_mode_o == ALL_MID));

  // R12: simultaneous trip picks over-voltage
  a_r12_ov_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && ov_dac_i && oc150_i && en_i && supply_ok_i) |=> ov_flag_o && !oc_flag_o);

endmodule

// File: tb/vr_seq_ctrl_bench.sv
module vr_seq_ctrl_bench;
  localparam int NPH = 3;
  localparam int CAL = 40;
  localparam int DRV = 25;
  localparam int OCD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, en = 1'b0, dron = 1'b0, ss_done = 1'b0;
  logic [NPH-1:0] pwm = '0;
  logic ov_abs = 1'b0, ov_dac = 1'b0, uv = 1'b0, oc100 = 1'b0, oc150 = 1'b0;
  logic [2*NPH-1:0] mode;
  logic drv_en, ready, ov_flag, oc_flag;

  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  vr_seq_ctrl #(.NPH(NPH), .CAL_CYC(CAL), .DRV_CYC(DRV), .OC_CYC(OCD)) u_vr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .en_i(en), .dron_i(dron),
    .ss_done_i(ss_done), .pwm_i(pwm), .ov_abs_i(ov_abs), .ov_dac_i(ov_dac),
    .uv_i(uv), .oc100_i(oc100), .oc150_i(oc150), .pwm_mode_o(mode),
    .drv_en_o(drv_en), .ready_o(ready), .ov_flag_o(ov_flag), .oc_flag_o(oc_flag));

  function automatic logic [2*NPH-1:0] all_of(input logic [1:0] m);
    return {NPH{m}};
  endfunction

  function automatic logic [2*NPH-1:0] soft_modes(input logic [NPH-1:0] released);
    logic [2*NPH-1:0] r;
    for (int i = 0; i < NPH; i++) r[2*i +: 2] = released[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bring_up_soft();
    en = 1'b1; dron = 1'b0; ss_done = 1'b0; pwm = '0;
    tick();
    for (int j = 1; j < CAL; j++) begin
      tick();
      chk("R2 cal modes", 32'(mode), 32'(all_of(2'b01)));
      chk("R2 drv enable", 32'(drv_en), 32'(j >= DRV));
    end
    tick();
    for (int k = 0; k < 3; k++) begin
      chk("R3 wait modes", 32'(mode), 32'(all_of(2'b01)));
      chk("R3 wait ready", 32'(ready), 0);
      tick();
    end
    dron = 1'b1;
    tick();
    chk("R4 soft start mid", 32'(mode), 32'(soft_modes(3'b000)));
    pwm = 3'b010; #1;
    chk("R4 first pulse", 32'(mode), 32'(soft_modes(3'b010)));
    tick(); pwm = '0; #1;
    chk("R4 stays active", 32'(mode), 32'(soft_modes(3'b010)));
    pwm = 3'b101; #1;
    tick(); pwm = '0; #1;
    chk("R4 all released", 32'(mode), 32'(soft_modes(3'b111)));
    chk("R4 soft ready", 32'(ready), 0);
  endtask

  task automatic bring_up_run();
    bring_up_soft();
    ss_done = 1'b1;
    tick();
    chk("R5 run modes", 32'(mode), 32'(all_of(2'b10)));
    chk("R5 run ready", 32'(ready), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset modes", 32'(mode), 32'(all_of(2'b01)));
    chk("R1 reset drv", 32'(drv_en), 0);
    chk("R1 reset flags", 32'({ready, ov_flag, oc_flag}), 0);
    supply_ok = 1'b1;
    tick();
    chk("R1 off modes", 32'(mode), 32'(all_of(2'b01)));

    bring_up_run();

    // R10 and R9: randomized stretch of regulation
    for (int n = 0; n < 40; n++) begin
      case ($urandom_range(0, 2))
        0: begin
          uv = 1'($urandom_range(0, 1));
          tick();
          chk("R10 ready follows uv", 32'(ready), 32'(!uv));
        end
        1: begin
          oc100 = 1'b1;
          repeat ($urandom_range(1, OCD - 1)) tick();
          oc100 = 1'b0;
          tick();
          chk("R9 short burst no trip", 32'(oc_flag), 0);
        end
        default: begin
          pwm = NPH'($urandom);
          tick();
          chk("R5 run stays active", 32'(mode), 32'(all_of(2'b10)));
        end
      endcase
    end
    uv = 1'b0; pwm = '0;
    tick();
    chk("R10 ready restored", 32'(ready), 1);

    ov_abs = 1'b1;
    tick();
    chk("R6 abs ignored in run", 32'({ov_flag, ready}), 32'(2'b01));
    ov_abs = 1'b0;

    oc100 = 1'b1;
    repeat (OCD - 1) tick();
    chk("R9 no trip before limit", 32'(oc_flag), 0);
    tick();
    chk("R9 trip at limit", 32'(oc_flag), 1);
    chk("R8 oc modes low", 32'(mode), 0);
    oc100 = 1'b0;
    tick();
    chk("R11 oc latched", 32'(oc_flag), 1);
    en = 1'b0;
    tick();
    chk("R11 enable clears oc", 32'(oc_flag), 0);
    chk("R1 off after enable low", 32'(mode), 32'(all_of(2'b01)));

    bring_up_run();
    oc150 = 1'b1;
    tick();
    chk("R8 immediate trip", 32'({oc_flag, ready}), 32'(2'b10));
    chk("R8 modes low", 32'(mode), 0);
    oc150 = 1'b0;
    en = 1'b0;
    tick();

    bring_up_run();
    ov_dac = 1'b1;
    tick();
    chk("R7 ov trip", 32'({ov_flag, ready}), 32'(2'b10));
    chk("R7 modes low", 32'(mode), 0);
    ov_dac = 1'b0;
    repeat (5) tick();
    chk("R7 ov latched", 32'(ov_flag), 1);
    supply_ok = 1'b0;
    tick();
    chk("R11 supply clears ov", 32'(ov_flag), 0);
    chk("R11 supply modes mid", 32'(mode), 32'(all_of(2'b01)));
    chk("R11 supply drv off", 32'(drv_en), 0);
    supply_ok = 1'b1;
    tick();

    bring_up_soft();
    ov_abs = 1'b1;
    tick();
    chk("R6 abs trip in soft", 32'(ov_flag), 1);
    ov_abs = 1'b0;
    en = 1'b0;
    tick();

    bring_up_soft();
    ov_dac = 1'b1;
    tick();
    chk("R6 dac ignored in soft", 32'(ov_flag), 0);
    ov_dac = 1'b0;
    ss_done = 1'b1;
    tick();
    ov_dac = 1'b1; oc150 = 1'b1;
    tick();
    chk("R12 ov wins", 32'({ov_flag, oc_flag}), 32'(2'b10));
    ov_dac = 1'b0; oc150 = 1'b0;
    en = 1'b0;
    tick();

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule